// File: doc/BRIEF.md
# Multi-Sector ID Stepper

This block follows the sector identifier (cylinder, head, sector number, size code) while a disk controller moves through a run of sectors on a read or write. A start pulse captures the first identifier, the last sector number of the track, the multi-track flag and the data-length byte. Each completed sector advances the identifier. The block also reports the sector byte length. When the run ends it produces the identifier and status flags for the result phase.

A run ends in one of two ways. The host can raise the terminal-count flag together with the completion of a sector, which is a normal end. Otherwise the run ends on its own at the track's last sector when it cannot carry on onto the other head, which is an abnormal end. The state machine has three states. `ST_IDLE` waits for `start`. `ST_XFER` advances on each `sec_done`. `ST_REPORT` drives `res_valid` for one cycle. The transitions are: IDLE to XFER on `start`; XFER to XFER on a plain advance or a head switch; XFER to REPORT on a final sector; REPORT to IDLE always.

Top module: `sector_id_stepper`

## Requirements
- R1: After reset `busy` and `res_valid` are 0.
- R2: `start` in idle loads C, H, R, N, last-sector, multi-track and data-length; `busy` is 1 from the next cycle, and `cur_*` show the loaded values. A `start` while busy has no effect on `cur_*`.
- R3: `sec_done` without `tc` on a sector below the last sector sets `cur_r` to R+1 and keeps C, H, N.
- R4: `sec_done` without `tc` on the last sector, with multi-track 1 and H bit 0 equal to 0, continues the run: H bit 0 inverts, `cur_r` becomes 1, C is kept, and `busy` stays 1.
- R5: A run that ends without `tc` reports `res_ic`=2'b01 and `res_en`=1. A run ended by `tc` reports `res_ic`=2'b00 and `res_en`=0.
- R6: Ending with `tc` on a sector below the last sector reports C, H, N unchanged and R+1.
- R7: Ending on the last sector with multi-track 0 reports C+1, H unchanged, R=0.
- R8: Ending (by `tc`) on the last sector with multi-track 1 and H bit 0 = 0 reports C unchanged, H bit 0 inverted, R=0.
- R9: Ending on the last sector with multi-track 1 and H bit 0 = 1 reports C+1, H bit 0 inverted, R=0.
- R10: `res_valid` is high for exactly the one cycle after the ending edge. `res_n` equals the loaded N. `busy` is 0 in that cycle and afterwards.
- R11: For N from 1 to 7, `sec_len` is 2^(N+7). An N above 7 gives the length of N=7, which is 16384.
- R12: For N=0, `sec_len` equals the loaded data-length byte.
- R13: `sec_done` and `tc` have no effect while not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Load start identifier and begin run |
| ld_c | input | 8 | Start cylinder |
| ld_h | input | 8 | Start head |
| ld_r | input | 8 | Start sector number |
| ld_n | input | 8 | Size code |
| ld_eot | input | 8 | Last sector number on the track |
| ld_mt | input | 1 | Multi-track flag |
| ld_dtl | input | 8 | Byte count per sector when N is 0 |
| sec_done | input | 1 | Current sector transfer finished |
| tc | input | 1 | Terminal count, valid with sec_done |
| busy | output | 1 | Run in progress |
| cur_c | output | 8 | Current cylinder |
| cur_h | output | 8 | Current head |
| cur_r | output | 8 | Current sector number |
| cur_n | output | 8 | Current size code |
| sec_len | output | 16 | Sector byte length |
| res_valid | output | 1 | Result identifier valid (one cycle) |
| res_c | output | 8 | Result cylinder |
| res_h | output | 8 | Result head |
| res_r | output | 8 | Result sector number |
| res_n | output | 8 | Result size code |
| res_ic | output | 2 | Interrupt code for status 0 |
| res_en | output | 1 | End-of-track flag for status 1 |

## Verification
Two things can happen on the same edge: reaching the last sector of the track, and being stopped by the terminal count. The bench provokes this by raising `tc` with `sec_done` on the last sector, both on head 0 with multi-track set and on head 1. The head-0 case, if `tc` were missing, would be a head switch. In both cases the scoreboard expects a normal result (interrupt code 0, end flag 0) with the identifier from the end-of-track rows. It also expects no continuation onto the other head.

// File: rtl/sid_pkg.sv
package sid_pkg;
    localparam int ID_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_XFER   = 2'd1,
        ST_REPORT = 2'd2
    } sid_state_e;

    typedef struct packed {
        logic [ID_W-1:0] c;
        logic [ID_W-1:0] h;
        logic [ID_W-1:0] r;
        logic [ID_W-1:0] n;
    } sid_id_t;
endpackage

// File: rtl/sid_next_calc.sv
module sid_next_calc
    import sid_pkg::*;
(
    input  sid_id_t         cur,
    input  logic [ID_W-1:0] eot,
    input  logic            mt,
    output logic            at_eot,
    output logic            cont,
    output sid_id_t         cont_id,
    output sid_id_t         res_id
);
    localparam logic [ID_W-1:0] ONE = ID_W'(1);

    always_comb begin
        at_eot  = (cur.r == eot);
        cont    = at_eot && mt && !cur.h[0];
        cont_id = cur;
        cont_id.h[0] = ~cur.h[0];
        cont_id.r    = ONE;
        res_id  = cur;
        if (!at_eot) begin
            res_id.r = cur.r + ONE;
        end else begin
            res_id.r = '0;
            if (mt) begin
                res_id.h[0] = ~cur.h[0];
                if (cur.h[0]) res_id.c = cur.c + ONE;
            end else begin
                res_id.c = cur.c + ONE;
            end
        end
    end
endmodule

// File: rtl/sid_len_calc.sv
module sid_len_calc
    import sid_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int N_MAX      = 7,
    parameter int BASE_SHIFT = 7
) (
    input  logic [ID_W-1:0]  n,
    input  logic [ID_W-1:0]  dtl,
    output logic [LEN_W-1:0] len
);
    localparam logic [ID_W-1:0] N_LIM = ID_W'(N_MAX);
    localparam logic [LEN_W-1:0] UNIT = LEN_W'(1);

    logic [ID_W-1:0] n_eff;

    always_comb begin
        n_eff = (n > N_LIM) ? N_LIM : n;
        if (n == '0) len = LEN_W'(dtl);
        else         len = UNIT << (n_eff + ID_W'(BASE_SHIFT));
    end
endmodule

// File: rtl/sector_id_stepper.sv
module sector_id_stepper
    import sid_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int N_MAX      = 7,
    parameter int BASE_SHIFT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       ld_c,
    input  logic [7:0]       ld_h,
    input  logic [7:0]       ld_r,
    input  logic [7:0]       ld_n,
    input  logic [7:0]       ld_eot,
    input  logic             ld_mt,
    input  logic [7:0]       ld_dtl,
    input  logic             sec_done,
    input  logic             tc,
    output logic             busy,
    output logic [7:0]       cur_c,
    output logic [7:0]       cur_h,
    output logic [7:0]       cur_r,
    output logic [7:0]       cur_n,
    output logic [LEN_W-1:0] sec_len,
    output logic             res_valid,
    output logic [7:0]       res_c,
    output logic [7:0]       res_h,
    output logic [7:0]       res_r,
    output logic [7:0]       res_n,
    output logic [1:0]       res_ic,
    output logic             res_en
);
    sid_state_e      state, state_nx;
    sid_id_t         cur, cont_id, res_id, res_q;
    logic [ID_W-1:0] eot, dtl;
    logic            mt, at_eot, cont, finish, abn_q;

    sid_next_calc u_next (
        .cur     (cur),
        .eot     (eot),
        .mt      (mt),
        .at_eot  (at_eot),
        .cont    (cont),
        .cont_id (cont_id),
        .res_id  (res_id)
    );

    sid_len_calc #(.LEN_W(LEN_W), .N_MAX(N_MAX), .BASE_SHIFT(BASE_SHIFT)) u_len (
        .n   (cur.n),
        .dtl (dtl),
        .len (sec_len)
    );

    assign finish = sec_done && (tc || (at_eot && !cont));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_XFER;
            ST_XFER:   if (sec_done && finish) state_nx = ST_REPORT;
            ST_REPORT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur   <= '0;
            eot   <= '0;
            dtl   <= '0;
            mt    <= 1'b0;
            res_q <= '0;
            abn_q <= 1'b0;
        end else if (state == ST_IDLE && start) begin
            cur   <= '{c: ld_c, h: ld_h, r: ld_r, n: ld_n};
            eot   <= ld_eot;
            dtl   <= ld_dtl;
            mt    <= ld_mt;
        end else if (state == ST_XFER && sec_done) begin
            if (finish) begin
                res_q <= res_id;
                abn_q <= !tc;
            end else if (cont) begin
                cur <= cont_id;
            end else begin
                cur.r <= res_id.r;
            end
        end
    end

    always_comb begin
        busy      = (state == ST_XFER);
        res_valid = (state == ST_REPORT);
        cur_c     = cur.c;
        cur_h     = cur.h;
        cur_r     = cur.r;
        cur_n     = cur.n;
        res_c     = res_q.c;
        res_h     = res_q.h;
        res_r     = res_q.r;
        res_n     = res_q.n;
        res_ic    = {1'b0, abn_q};
        res_en    = abn_q;
    end
endmodule

// File: rtl/sid_checker.sv
module sid_checker #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             res_valid,
    input logic             sec_done,
    input logic             tc,
    input logic [7:0]       cur_r,
    input logic [7:0]       cur_h,
    input logic [7:0]       cur_n,
    input logic [7:0]       eot,
    input logic             mt,
    input logic [1:0]       res_ic,
    input logic             res_en,
    input logic [LEN_W-1:0] sec_len
);
    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid && !busy); // R10

    AST_ADVANCE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && sec_done && !tc && (cur_r != eot) |=> busy && (cur_r == 8'($past(cur_r) + 8'd1))); // R3

    AST_HEAD_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        busy && sec_done && !tc && (cur_r == eot) && mt && !cur_h[0]
        |=> busy && (cur_r == 8'd1) && cur_h[0]); // R4

    AST_TC_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        busy && sec_done && tc |=> res_valid && (res_ic == 2'b00) && !res_en); // R5

    AST_FLAG_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_ic[1] == 1'b0) && (res_ic[0] == res_en)); // R5

    AST_LEN_POW2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (cur_n != 8'd0) |-> ($countones(sec_len) == 1)); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !res_valid && sec_done |=> !res_valid); // R13
endmodule

bind sector_id_stepper sid_checker #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .res_valid (res_valid),
    .sec_done  (sec_done),
    .tc        (tc),
    .cur_r     (cur_r),
    .cur_h     (cur_h),
    .cur_n     (cur_n),
    .eot       (eot),
    .mt        (mt),
    .res_ic    (res_ic),
    .res_en    (res_en),
    .sec_len   (sec_len)
);

// File: tb/sector_id_stepper_test.sv
module sector_id_stepper_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  ld_c = '0, ld_h = '0, ld_r = '0, ld_n = '0, ld_eot = '0, ld_dtl = '0;
    logic        ld_mt = 1'b0;
    logic        sec_done = 1'b0, tc = 1'b0;
    logic        busy, res_valid, res_en;
    logic [7:0]  cur_c, cur_h, cur_r, cur_n, res_c, res_h, res_r, res_n;
    logic [15:0] sec_len;
    logic [1:0]  res_ic;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [7:0] c, h, r, n;
        logic [1:0] ic;
        logic       en;
    } res_t;
    res_t exp_q[$];

    always #2.5 clk = ~clk;

    sector_id_stepper uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ld_c(ld_c), .ld_h(ld_h), .ld_r(ld_r), .ld_n(ld_n),
        .ld_eot(ld_eot), .ld_mt(ld_mt), .ld_dtl(ld_dtl),
        .sec_done(sec_done), .tc(tc), .busy(busy),
        .cur_c(cur_c), .cur_h(cur_h), .cur_r(cur_r), .cur_n(cur_n),
        .sec_len(sec_len), .res_valid(res_valid),
        .res_c(res_c), .res_h(res_h), .res_r(res_r), .res_n(res_n),
        .res_ic(res_ic), .res_en(res_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [7:0] c, h, r, n, e, input logic m, input logic [7:0] d);
        @(posedge clk); #1;
        start = 1'b1; ld_c = c; ld_h = h; ld_r = r; ld_n = n; ld_eot = e; ld_mt = m; ld_dtl = d;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic step(input logic t);
        @(posedge clk); #1;
        sec_done = 1'b1; tc = t;
        @(posedge clk); #1;
        sec_done = 1'b0; tc = 1'b0;
    endtask

    task automatic expect_res(input logic [7:0] c, h, r, n, input logic abn);
        exp_q.push_back('{c: c, h: h, r: r, n: n, ic: {1'b0, abn}, en: abn});
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
                tests++; fails++;
                $display("FAIL R13 unexpected result actual=1 expected=0");
            end else begin
                res_t e;
                e = exp_q.pop_front();
                chk("R6-R9 res_c", res_c, e.c);
                chk("R6-R9 res_h", res_h, e.h);
                chk("R6-R9 res_r", res_r, e.r);
                chk("R10 res_n", res_n, e.n);
                chk("R5 res_ic", res_ic, e.ic);
                chk("R5 res_en", res_en, e.en);
                chk("R10 busy low with result", busy, 0);
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #12;
        chk("R1 busy", busy, 0);
        chk("R1 res_valid", res_valid, 0);
        rst_n = 1'b1;

        // R2, R3, R11, R6: normal run ended by tc below last sector
        do_load(8'd5, 8'd0, 8'd1, 8'd2, 8'd3, 1'b0, 8'h80);
        chk("R2 busy", busy, 1);
        chk("R2 cur_c", cur_c, 5);
        chk("R2 cur_r", cur_r, 1);
        chk("R11 len N=2", sec_len, 512);
        do_load(8'd99, 8'd1, 8'd7, 8'd3, 8'd9, 1'b1, 8'h10);
        chk("R2 ignored start cur_c", cur_c, 5);
        chk("R2 ignored start cur_r", cur_r, 1);
        step(1'b0);
        chk("R3 cur_r", cur_r, 2);
        chk("R3 cur_c", cur_c, 5);
        chk("R3 cur_n", cur_n, 2);
        expect_res(8'd5, 8'd0, 8'd3, 8'd2, 1'b0);
        step(1'b1);
        #5;
        chk("R10 idle after result", busy, 0);

        // R13: idle sec_done / tc ignored
        step(1'b1);
        chk("R13 cur_r unchanged", cur_r, 2);
        chk("R13 busy", busy, 0);

        // R7, R5: ends at last sector, mt=0, no tc
        do_load(8'd7, 8'd0, 8'd3, 8'd2, 8'd3, 1'b0, 8'h00);
        expect_res(8'd8, 8'd0, 8'd0, 8'd2, 1'b1);
        step(1'b0);
        #5;

        // R4, R9: head switch then tc at last sector of head 1
        do_load(8'd2, 8'd0, 8'd2, 8'd1, 8'd2, 1'b1, 8'h00);
        chk("R11 len N=1", sec_len, 256);
        step(1'b0);
        chk("R4 cur_h", cur_h, 1);
        chk("R4 cur_r", cur_r, 1);
        chk("R4 cur_c", cur_c, 2);
        chk("R4 busy", busy, 1);
        step(1'b0);
        chk("R3 cur_r after switch", cur_r, 2);
        expect_res(8'd3, 8'd0, 8'd0, 8'd1, 1'b0);
        step(1'b1);
        #5;

        // R8: tc at last sector, mt=1, head 0 (same-cycle case)
        do_load(8'd4, 8'd0, 8'd9, 8'd2, 8'd9, 1'b1, 8'h00);
        expect_res(8'd4, 8'd1, 8'd0, 8'd2, 1'b0);
        step(1'b1);
        #5;

        // R9, R5: head 1, mt=1, no tc -> abnormal end
        do_load(8'd10, 8'd1, 8'd5, 8'd3, 8'd5, 1'b1, 8'h00);
        chk("R11 len N=3", sec_len, 1024);
        expect_res(8'd11, 8'd0, 8'd0, 8'd3, 1'b1);
        step(1'b0);
        #5;

        // R12: N=0 uses data length
        do_load(8'd0, 8'd0, 8'd1, 8'd0, 8'd5, 1'b0, 8'h40);
        chk("R12 len dtl", sec_len, 16'h40);
        expect_res(8'd0, 8'd0, 8'd2, 8'd0, 1'b0);
        step(1'b1);
        #5;

        // R11: N above 7 clamps
        do_load(8'd0, 8'd0, 8'd1, 8'd9, 8'd5, 1'b0, 8'h00);
        chk("R11 len clamp", sec_len, 16384);
        do_load(8'd0, 8'd0, 8'd1, 8'd7, 8'd5, 1'b0, 8'h00);
        chk("R11 busy unchanged by start", cur_n, 9);
        expect_res(8'd0, 8'd0, 8'd2, 8'd9, 1'b0);
        step(1'b1);
        #10;
        chk("R10 queue drained", exp_q.size(), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule